// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Sequencer

This block runs the bus cycles of an 8-bit external memory bus on which the low address byte and the data byte share one set of lines. A client raises a one-cycle start with an address, up to 32 bits of write data, a read/write flag, a program/data space flag and a size code. The sequencer then works through each byte cycle in turn. First comes an address phase, in which the high address byte sits on its own lines, the low byte sits on the shared lines and a latch strobe pulses. A setup phase follows, and then a strobe window of a fixed number of wait cycles.

A glue section inside the block models the external demultiplexing latch and a 3-to-8 chip-select decoder. It gives the memory side a stable 16-bit address, one select, and a read enable that is the OR of the data-read and program-fetch strobes. Values wider than a byte are moved as a run of complete byte cycles to rising adjacent addresses. The lowest address carries the least significant byte.

Top module: `muxbus_ctrl`

## Requirements
- R1: A byte cycle opens with exactly one cycle in which `ale` is high, `ad_oe` is high, `ad_out` carries address bits 7:0 and `addr_hi` carries address bits 15:8.
- R2: `lat_lo` takes `ad_out` on the clock edge that closes the `ale` cycle, and it stays unchanged for the rest of that byte cycle.
- R3: In a write, the data byte is placed on `ad_out` with `ad_oe` high in every cycle after the address phase, through the end of the strobe window.
- R4: At most one strobe is active at any time. A write uses `strb_wr`, a data-space read uses `strb_rd` and a program-space read uses `strb_pf`. The active strobe starts one cycle after the address phase and stays asserted for exactly WAIT_CYC cycles.
- R5: A read byte is sampled from `ad_in` on the clock edge that ends the strobe window, which is the last cycle in which the strobe is active.
- R6: `mem_rd_en` is active exactly when `strb_rd` or `strb_pf` is active.
- R7: While busy, exactly one chip select is high, chosen by `addr_hi[2:0]`: values 0 to 3 select `cs_ram`, 4 and 5 select `cs_flash`, 6 selects `cs_io0` and 7 selects `cs_io1`. While idle, no select is high.
- R8: Size code 0 makes one byte cycle, code 1 makes two and codes 2 and 3 make four. The byte cycles use addresses base, base+1 and so on, wrapping modulo 2^16.
- R9: `rsp_rdata` holds the read bytes in little-endian order, with unread upper bytes zero. `done` is a one-cycle pulse that is raised after the last byte, n*(WAIT_CYC+2) cycles after start is taken for n bytes.
- R10: `ad_oe` is low while idle and throughout the setup and strobe phases of a read.
- R11: `busy` is high from the cycle after start is accepted until `done`. A start seen while busy has no effect on the transfer in progress and does not launch another one.
- R12: After reset, `busy`, `done`, `ale`, `ad_oe`, every strobe, `mem_rd_en` and every chip select are inactive.
- R13: With STROBE_HIGH=1 (the default), an active strobe or read enable is a 1. With STROBE_HIGH=0, these outputs are inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | Start a transfer (taken only when idle) |
| req_addr | input | 16 | Base byte address |
| req_wdata | input | 32 | Write value, little-endian |
| req_write | input | 1 | 1 = write, 0 = read |
| req_prog | input | 1 | 1 = program space read |
| req_size | input | 2 | 0: 8-bit, 1: 16-bit, 2/3: 32-bit |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Assembled read value |
| ad_out | output | 8 | Shared lines, driven value |
| ad_in | input | 8 | Shared lines, sampled value |
| ad_oe | output | 1 | Drive enable for shared lines |
| ale | output | 1 | Address latch strobe |
| addr_hi | output | 8 | Address bits 15:8 |
| strb_rd | output | 1 | Data read strobe |
| strb_wr | output | 1 | Write strobe |
| strb_pf | output | 1 | Program fetch strobe |
| mem_rd_en | output | 1 | Memory read enable (OR of read strobes) |
| lat_lo | output | 8 | Latched address bits 7:0 |
| cs_ram | output | 1 | RAM select |
| cs_flash | output | 1 | Flash select |
| cs_io0 | output | 1 | First parallel I/O select |
| cs_io1 | output | 1 | Second parallel I/O select |

## Verification
Every size code is crossed with writes, data reads and program reads over eight base addresses. These addresses reach all eight decoder values, cross a high-byte boundary and wrap past 0xFFFF. The crossing separates a true 16-bit increment from a byte-only increment and confirms that the chip select follows each byte. The memory model places valid data only in the last strobe cycle, so a design that samples early reads a marker byte instead. Every other transfer also raises a second start while busy, using a complemented address, to show that the request is dropped.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_SETUP, PH_STRB} phase_t;

  // number of byte cycles for a size code
  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    size_bytes = 3'd1;
      2'd1:    size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

  // address of byte idx of a transfer, wrapping in 16 bits
  function automatic logic [15:0] byte_addr(input logic [15:0] base, input logic [1:0] idx);
    byte_addr = base + {14'd0, idx};
  endfunction
endpackage

// File: rtl/mbc_seq.sv
module mbc_seq import muxbus_pkg::*; #(
  parameter int WAIT_CYC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] addr,
  input  logic [31:0] wdata,
  input  logic        write,
  input  logic        prog,
  input  logic [1:0]  size,
  input  logic [7:0]  ad_in,
  output logic [15:0] cur_addr,
  output logic [7:0]  ad_out,
  output logic        ad_oe,
  output logic        ale,
  output logic        act_rd,
  output logic        act_wr,
  output logic        act_pf,
  output logic        busy,
  output logic        done,
  output logic [31:0] rdata
);
  localparam int CW = (WAIT_CYC < 2) ? 1 : $clog2(WAIT_CYC);
  localparam logic [CW-1:0] LAST_W = CW'(WAIT_CYC - 1);

  phase_t      ph;
  logic [15:0] base;
  logic [31:0] wbuf;
  logic        is_wr, is_pf;
  logic [2:0]  nb;
  logic [1:0]  idx;
  logic [CW-1:0] wcnt;
  logic        done_q;

  // named events
  logic win_end, last_byte;
  assign win_end   = (ph == PH_STRB) && (wcnt == LAST_W);
  assign last_byte = ({1'b0, idx} == nb - 3'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= PH_IDLE; base <= '0; wbuf <= '0; is_wr <= 1'b0; is_pf <= 1'b0;
      nb <= 3'd1; idx <= '0; wcnt <= '0; rdata <= '0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (ph)
        PH_IDLE: if (start) begin
          base <= addr; wbuf <= wdata; is_wr <= write; is_pf <= prog & ~write;
          nb <= size_bytes(size); idx <= '0; rdata <= '0; ph <= PH_ADDR;
        end
        PH_ADDR:  ph <= PH_SETUP;
        PH_SETUP: begin ph <= PH_STRB; wcnt <= '0; end
        PH_STRB: begin
          if (win_end) begin
            if (!is_wr) rdata[{idx, 3'b000} +: 8] <= ad_in;
            if (last_byte) begin
              ph <= PH_IDLE; done_q <= 1'b1;
            end else begin
              idx <= idx + 2'd1; ph <= PH_ADDR;
            end
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign cur_addr = byte_addr(base, idx);
  assign ale      = (ph == PH_ADDR);
  assign ad_oe    = ale | (is_wr & ((ph == PH_SETUP) | (ph == PH_STRB)));
  assign ad_out   = ale ? cur_addr[7:0] : (ad_oe ? wbuf[{idx, 3'b000} +: 8] : 8'h00);
  assign act_wr   = (ph == PH_STRB) & is_wr;
  assign act_rd   = (ph == PH_STRB) & ~is_wr & ~is_pf;
  assign act_pf   = (ph == PH_STRB) & ~is_wr & is_pf;
  assign busy     = (ph != PH_IDLE);
  assign done     = done_q;
endmodule

// File: rtl/mbc_dec.sv
module mbc_dec #(
  parameter int SEL_W = 3
) (
  input  logic [SEL_W-1:0]    sel,
  input  logic                en,
  output logic [2**SEL_W-1:0] y
);
  localparam int NOUT = 2 ** SEL_W;
  for (genvar i = 0; i < NOUT; i++) begin : g_out
    assign y[i] = en && (sel == SEL_W'(i));
  end
endmodule

// File: rtl/mbc_glue.sv
module mbc_glue (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ale,
  input  logic [7:0] ad_bus,
  input  logic [7:0] addr_hi,
  input  logic       cyc_on,
  output logic [7:0] lat_lo,
  output logic       cs_ram,
  output logic       cs_flash,
  output logic       cs_io0,
  output logic       cs_io1
);
  logic [7:0] y;

  // demultiplexing latch: takes the low byte while the strobe is high
  always_ff @(posedge clk) begin
    if (!rst_n)   lat_lo <= '0;
    else if (ale) lat_lo <= ad_bus;
  end

  mbc_dec #(.SEL_W(3)) u_dec (.sel(addr_hi[2:0]), .en(cyc_on), .y(y));

  assign cs_ram   = |y[3:0];
  assign cs_flash = |y[5:4];
  assign cs_io0   = y[6];
  assign cs_io1   = y[7];
endmodule

// File: rtl/muxbus_ctrl.sv
module muxbus_ctrl #(
  parameter int WAIT_CYC    = 2,
  parameter bit STROBE_HIGH = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_start,
  input  logic [15:0] req_addr,
  input  logic [31:0] req_wdata,
  input  logic        req_write,
  input  logic        req_prog,
  input  logic [1:0]  req_size,
  output logic        busy,
  output logic        done,
  output logic [31:0] rsp_rdata,
  output logic [7:0]  ad_out,
  input  logic [7:0]  ad_in,
  output logic        ad_oe,
  output logic        ale,
  output logic [7:0]  addr_hi,
  output logic        strb_rd,
  output logic        strb_wr,
  output logic        strb_pf,
  output logic        mem_rd_en,
  output logic [7:0]  lat_lo,
  output logic        cs_ram,
  output logic        cs_flash,
  output logic        cs_io0,
  output logic        cs_io1
);
  logic [15:0] cur_addr;
  logic act_rd, act_wr, act_pf;

  mbc_seq #(.WAIT_CYC(WAIT_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(req_start), .addr(req_addr),
    .wdata(req_wdata), .write(req_write), .prog(req_prog), .size(req_size),
    .ad_in(ad_in), .cur_addr(cur_addr), .ad_out(ad_out), .ad_oe(ad_oe),
    .ale(ale), .act_rd(act_rd), .act_wr(act_wr), .act_pf(act_pf),
    .busy(busy), .done(done), .rdata(rsp_rdata)
  );

  assign addr_hi = busy ? cur_addr[15:8] : 8'h00;

  mbc_glue u_glue (
    .clk(clk), .rst_n(rst_n), .ale(ale), .ad_bus(ad_out), .addr_hi(addr_hi),
    .cyc_on(busy), .lat_lo(lat_lo), .cs_ram(cs_ram), .cs_flash(cs_flash),
    .cs_io0(cs_io0), .cs_io1(cs_io1)
  );

  // polarity applied at the pins
  assign strb_rd   = act_rd ~^ STROBE_HIGH;
  assign strb_wr   = act_wr ~^ STROBE_HIGH;
  assign strb_pf   = act_pf ~^ STROBE_HIGH;
  assign mem_rd_en = (act_rd | act_pf) ~^ STROBE_HIGH;
endmodule

// File: rtl/mbc_chk.sv
module mbc_chk #(
  parameter bit STROBE_HIGH = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       ale,
  input logic       ad_oe,
  input logic [7:0] lat_lo,
  input logic       strb_rd,
  input logic       strb_wr,
  input logic       strb_pf,
  input logic       cs_ram,
  input logic       cs_flash,
  input logic       cs_io0,
  input logic       cs_io1
);
  logic rd_a, wr_a, pf_a;
  logic [3:0] cs_v;
  assign rd_a = (strb_rd == STROBE_HIGH);
  assign wr_a = (strb_wr == STROBE_HIGH);
  assign pf_a = (strb_pf == STROBE_HIGH);
  assign cs_v = {cs_io1, cs_io0, cs_flash, cs_ram};

  a_r1_ale_drives: assert property (@(posedge clk) disable iff (!rst_n) ale |-> ad_oe);
  a_r1_ale_single: assert property (@(posedge clk) disable iff (!rst_n) ale |=> !ale);
  a_r2_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ale && $past(busy) && !$past(ale)) |-> $stable(lat_lo));
  a_r3_write_drive: assert property (@(posedge clk) disable iff (!rst_n) wr_a |-> ad_oe);
  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({rd_a, wr_a, pf_a}));
  a_r4_no_ale_strobe: assert property (@(posedge clk) disable iff (!rst_n) ale |-> !(rd_a || wr_a || pf_a));
  a_r7_cs_busy: assert property (@(posedge clk) disable iff (!rst_n) busy |-> $onehot(cs_v));
  a_r7_cs_idle: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (cs_v == 4'b0000));
  a_r10_release: assert property (@(posedge clk) disable iff (!rst_n) (rd_a || pf_a) |-> !ad_oe);
  a_r10_idle_float: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !ad_oe);
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  a_r11_busy_end: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done);
endmodule

bind muxbus_ctrl mbc_chk #(.STROBE_HIGH(STROBE_HIGH)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .ale(ale), .ad_oe(ad_oe),
  .lat_lo(lat_lo), .strb_rd(strb_rd), .strb_wr(strb_wr), .strb_pf(strb_pf),
  .cs_ram(cs_ram), .cs_flash(cs_flash), .cs_io0(cs_io0), .cs_io1(cs_io1)
);

// File: tb/sim_muxbus_ctrl.sv
module sim_muxbus_ctrl;
  localparam int PER = 10;
  localparam int W   = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_start = 1'b0, req_write = 1'b0, req_prog = 1'b0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [1:0]  req_size = '0;
  logic busy, done, ad_oe, ale, strb_rd, strb_wr, strb_pf, mem_rd_en;
  logic cs_ram, cs_flash, cs_io0, cs_io1;
  logic [31:0] rsp_rdata;
  logic [7:0] ad_out, ad_in, addr_hi, lat_lo;

  int checks = 0, errors = 0;
  int age = 0;

  always #(PER/2) clk = ~clk;

  muxbus_ctrl #(.WAIT_CYC(W), .STROBE_HIGH(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_write(req_write), .req_prog(req_prog),
    .req_size(req_size), .busy(busy), .done(done), .rsp_rdata(rsp_rdata),
    .ad_out(ad_out), .ad_in(ad_in), .ad_oe(ad_oe), .ale(ale), .addr_hi(addr_hi),
    .strb_rd(strb_rd), .strb_wr(strb_wr), .strb_pf(strb_pf), .mem_rd_en(mem_rd_en),
    .lat_lo(lat_lo), .cs_ram(cs_ram), .cs_flash(cs_flash), .cs_io0(cs_io0), .cs_io1(cs_io1)
  );

  function automatic logic [7:0] mem_pat(input logic [15:0] a);
    return (a[7:0] * 8'd3) ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic logic [3:0] cs_exp(input logic [2:0] s);
    if (s < 3'd4)       return 4'b0001;
    else if (s < 3'd6)  return 4'b0010;
    else if (s == 3'd6) return 4'b0100;
    else                return 4'b1000;
  endfunction

  // slow memory: valid data only in the final strobe cycle
  always @(posedge clk) age <= mem_rd_en ? age + 1 : 0;
  assign ad_in = (mem_rd_en && age >= W - 1) ? mem_pat({addr_hi, lat_lo}) : 8'hEE;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expectations shared with the monitor
  logic [15:0] e_base;
  logic [31:0] e_wdata;
  bit e_wr, e_pf;
  int e_n, bidx, slen;
  bit prev_act = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      automatic bit act = strb_rd | strb_wr | strb_pf;
      automatic logic [15:0] ea = e_base + 16'(bidx);
      if (ale) begin
        chk(ad_oe && ad_out == ea[7:0] && addr_hi == ea[15:8], "R1 address phase",
            {ad_oe, 7'd0, addr_hi, ad_out}, {1'b1, 7'd0, ea});
      end
      if (act && !prev_act) begin
        chk({addr_hi, lat_lo} == ea, "R2/R8 latched address", {addr_hi, lat_lo}, ea);
        chk({strb_wr, strb_rd, strb_pf} == {e_wr, !e_wr && !e_pf, !e_wr && e_pf},
            "R4 strobe kind", {strb_wr, strb_rd, strb_pf}, {e_wr, !e_wr && !e_pf, !e_wr && e_pf});
        chk(mem_rd_en == (strb_rd | strb_pf), "R6 read enable", mem_rd_en, strb_rd | strb_pf);
        chk({cs_io1, cs_io0, cs_flash, cs_ram} == cs_exp(addr_hi[2:0]), "R7 chip select",
            {cs_io1, cs_io0, cs_flash, cs_ram}, cs_exp(addr_hi[2:0]));
        if (e_wr)
          chk(ad_oe && ad_out == e_wdata[8*bidx +: 8], "R3 write data",
              {ad_oe, ad_out}, {1'b1, e_wdata[8*bidx +: 8]});
        else
          chk(!ad_oe, "R10 released on read", ad_oe, 0);
        bidx++;
        slen = 1;
      end else if (act) begin
        slen++;
      end
      if (!act && prev_act) chk(slen == W, "R4 strobe length", slen, W);
      prev_act = act;
    end
  end

  task automatic xfer(input logic [15:0] a, input logic [31:0] wd, input bit wr,
                      input bit pf, input logic [1:0] sz, input bit inject);
    int n, cnt;
    logic [31:0] exp_rd;
    n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    e_base = a; e_wdata = wd; e_wr = wr; e_pf = pf; e_n = n; bidx = 0;
    exp_rd = '0;
    for (int k = 0; k < n; k++) exp_rd[8*k +: 8] = mem_pat(a + 16'(k));
    @(negedge clk);
    req_start = 1; req_addr = a; req_wdata = wd; req_write = wr; req_prog = pf; req_size = sz;
    @(negedge clk);
    req_start = 0;
    chk(busy, "R11 busy after start", busy, 1);
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
      if (inject && cnt == 2) begin
        req_start = 1; req_addr = ~a; req_write = !wr; req_size = 2'd3;
      end
      if (inject && cnt == 3) req_start = 0;
    end while (!done && cnt < 100);
    chk(cnt == n * (W + 2), "R9 latency", cnt, n * (W + 2));
    chk(bidx == n, "R8 byte count", bidx, n);
    chk(!busy, "R11 idle at done", busy, 0);
    if (!wr) chk(rsp_rdata == exp_rd, "R5/R9 read value", rsp_rdata, exp_rd);
    @(negedge clk);
    chk(!busy && !done && !ad_oe, "R11/R10 no extra cycle", {busy, done, ad_oe}, 0);
  endtask

  initial begin
    #(PER * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] bases [8];
    bases = '{16'h0000, 16'h01FE, 16'h02FF, 16'h0377, 16'h04FD, 16'h05C0, 16'h06FF, 16'hFFFE};
    repeat (3) @(negedge clk);
    chk({busy, done, ale, ad_oe, strb_rd, strb_wr, strb_pf, mem_rd_en,
         cs_ram, cs_flash, cs_io0, cs_io1} == 0, "R12/R13 reset state",
        {busy, done, ale, ad_oe, strb_rd, strb_wr, strb_pf, mem_rd_en,
         cs_ram, cs_flash, cs_io0, cs_io1}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!ad_oe && !busy, "R10 idle released", {ad_oe, busy}, 0);
    for (int sz = 0; sz < 4; sz++)
      for (int kind = 0; kind < 3; kind++)
        for (int b = 0; b < 8; b++)
          xfer(bases[b], {bases[b] ^ 16'h5AA5, ~bases[b]}, kind == 0, kind == 2,
               2'(sz), (b % 2) == 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule